// File: doc/BRIEF.md
# Burst-Drained Dual-Clock Pixel Buffer

This block sits between a video decode pipeline and a downstream consumer that runs on its own unrelated clock. Pixel words enter on the write clock with two qualifiers: one marks active-video samples and the other marks control codes. Words that carry either qualifier are stored. Words that carry neither, such as blanking samples, are dropped at the input. The consumer pops stored words with a read-enable on its own clock. Each pointer crosses to the other domain as Gray code through a synchronizer chain, and each domain computes its own fill level.

The data-valid output has hysteresis so that the consumer drains in bursts. It rises once the read-side fill level reaches the almost-full threshold. It stays high until the fill falls to the almost-empty threshold. The write side raises its own almost-full flag against the same threshold. A write that arrives while the buffer is full sets a sticky overflow flag, so a consumer that is too slow can be detected. Both thresholds are static configuration inputs, and the almost-empty threshold must be lower than the almost-full threshold.

Top module: `burst_pix_fifo`

## Requirements
- R1: A word is stored only if `wr_active` or `wr_ctrl` is high at the write clock edge. A word with both low is discarded, and no later read returns it.
- R2: Stored words are read out in the order they were written, across the two asynchronous clocks, with `DATA_W` bits kept (20 by default).
- R3: `rd_pix` is registered. It takes the popped word at the same read clock edge that samples `rd_en` high, so the word is visible during the following read cycle. It holds its value in every cycle without a pop.
- R4: `rd_en` while the buffer is empty is ignored. `rd_pix` holds, the read pointer does not move, and the next word written is the next word read.
- R5: `almost_full` (write domain) is high exactly when the write-side fill is at or above `afull_lvl`.
- R6: `data_valid` rises when the read-side fill reaches `afull_lvl`. It then stays high while the fill is above `aempty_lvl`, and falls when the fill is at or below `aempty_lvl`. Between the two thresholds it keeps its previous value.
- R7: A qualified write while the buffer is full is dropped. It sets `overflow`, which stays high until reset.
- R8: While reset is held and after it is released, both pointers are cleared: the buffer is empty, and `almost_full`, `overflow`, `data_valid` and `rd_pix` are all zero.
- R9: The buffer holds exactly 2**`ADDR_W` words (512 by default). It never holds more, and the word that arrives after it is full is the first one dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| wr_clk | input | 1 | Write-side pixel clock |
| wr_pix | input | DATA_W | Incoming pixel or control word |
| wr_active | input | 1 | Marks `wr_pix` as an active-video sample |
| wr_ctrl | input | 1 | Marks `wr_pix` as a control code |
| almost_full | output | 1 | Write-side fill at or above `afull_lvl` |
| overflow | output | 1 | Sticky flag: a qualified write was dropped while full |
| rd_clk | input | 1 | Read-side clock, asynchronous to `wr_clk` |
| rd_en | input | 1 | Pop request from the consumer |
| rd_pix | output | DATA_W | Registered read word |
| data_valid | output | 1 | Burst-ready indication with hysteresis |
| afull_lvl | input | ADDR_W+1 | Almost-full threshold (static) |
| aempty_lvl | input | ADDR_W+1 | Almost-empty threshold (static, below `afull_lvl`) |

## Verification
The bench builds the block with `ADDR_W` set to 4 and `DATA_W` kept at 20. With 16 entries, the full boundary, the dropped writes that follow it and the sticky overflow flag are reached within a few dozen writes. The thresholds are fixed at 12 and 4, so the data-valid hysteresis can be walked entry by entry on both sides: rising at 12, holding at 5, falling at 4, and staying low when the fill climbs back to 11. The read clock runs at a period unrelated to the 125 MHz write clock, so the Gray-coded crossings are exercised at changing phases.

// File: rtl/bf_pkg.sv
package bf_pkg;
  // Default geometry of the buffer and depth of each pointer synchronizer.
  localparam int unsigned BF_DATA_W      = 20;
  localparam int unsigned BF_ADDR_W      = 9;
  localparam int unsigned BF_SYNC_STAGES = 2;
endpackage

// File: rtl/bf_rst_sync.sv
module bf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q, out_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      out_q  <= meta_q;
    end
  end

  assign srst_n = out_q;
endmodule

// File: rtl/bf_ptr_sync.sv
module bf_ptr_sync #(
  parameter int unsigned W      = 10,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] gray_out
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stg_d;
    if (s == 0) begin : g_first
      assign stg_d = gray_in;
    end else begin : g_next
      assign stg_d = stg_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_d;
    end
  end

  assign gray_out = stg_q[STAGES-1];
endmodule

// File: rtl/bf_wr_ctl.sv
module bf_wr_ctl #(
  parameter int unsigned ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic [ADDR_W:0]   rd_gray_s,
  input  logic [ADDR_W:0]   afull_lvl,
  output logic              mem_we,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W:0]   wr_gray,
  output logic              almost_full,
  output logic              overflow
);
  localparam logic [ADDR_W:0] FULL_LVL = {1'b1, {ADDR_W{1'b0}}};

  logic [ADDR_W:0] wr_bin_q, wr_bin_d;
  logic [ADDR_W:0] wr_gray_q, wr_gray_d;
  logic [ADDR_W:0] rd_bin_s, fill_now, fill_after;
  logic            full, accept;
  logic            af_q, af_d, ovf_q, ovf_d;

  always_comb begin
    for (int i = 0; i <= int'(ADDR_W); i++) begin
      rd_bin_s[i] = ^(rd_gray_s >> i);
    end
    fill_now   = wr_bin_q - rd_bin_s;
    full       = (fill_now == FULL_LVL);
    accept     = push_req & ~full;
    wr_bin_d   = wr_bin_q + {{ADDR_W{1'b0}}, accept};
    wr_gray_d  = wr_bin_d ^ (wr_bin_d >> 1);
    fill_after = wr_bin_d - rd_bin_s;
    af_d       = (fill_after >= afull_lvl);
    ovf_d      = ovf_q | (push_req & full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_bin_q  <= '0;
      wr_gray_q <= '0;
      af_q      <= 1'b0;
      ovf_q     <= 1'b0;
    end else begin
      if (accept) begin
        wr_bin_q  <= wr_bin_d;
        wr_gray_q <= wr_gray_d;
      end
      af_q  <= af_d;
      ovf_q <= ovf_d;
    end
  end

  assign mem_we      = accept;
  assign wr_addr     = wr_bin_q[ADDR_W-1:0];
  assign wr_gray     = wr_gray_q;
  assign almost_full = af_q;
  assign overflow    = ovf_q;

  // R9
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_now <= FULL_LVL);

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
endmodule

// File: rtl/bf_rd_ctl.sv
module bf_rd_ctl #(
  parameter int unsigned ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W:0]   wr_gray_s,
  input  logic [ADDR_W:0]   afull_lvl,
  input  logic [ADDR_W:0]   aempty_lvl,
  output logic              pop,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W:0]   rd_gray,
  output logic              data_valid
);
  logic [ADDR_W:0] rd_bin_q, rd_bin_d;
  logic [ADDR_W:0] rd_gray_q, rd_gray_d;
  logic [ADDR_W:0] wr_bin_s, fill_now, fill_after;
  logic            empty, pop_int;
  logic            dv_q, dv_d;

  always_comb begin
    for (int i = 0; i <= int'(ADDR_W); i++) begin
      wr_bin_s[i] = ^(wr_gray_s >> i);
    end
    fill_now   = wr_bin_s - rd_bin_q;
    empty      = (fill_now == '0);
    pop_int    = rd_en & ~empty;
    rd_bin_d   = rd_bin_q + {{ADDR_W{1'b0}}, pop_int};
    rd_gray_d  = rd_bin_d ^ (rd_bin_d >> 1);
    fill_after = wr_bin_s - rd_bin_d;
    dv_d       = dv_q;
    if (fill_after >= afull_lvl)       dv_d = 1'b1;
    else if (fill_after <= aempty_lvl) dv_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_bin_q  <= '0;
      rd_gray_q <= '0;
      dv_q      <= 1'b0;
    end else begin
      if (pop_int) begin
        rd_bin_q  <= rd_bin_d;
        rd_gray_q <= rd_gray_d;
      end
      dv_q <= dv_d;
    end
  end

  assign pop        = pop_int;
  assign rd_addr    = rd_bin_q[ADDR_W-1:0];
  assign rd_gray    = rd_gray_q;
  assign data_valid = dv_q;

  // R4
  empty_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty) |=> $stable(rd_bin_q));

  // R6
  dv_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dv_q) |-> (fill_now >= afull_lvl));
endmodule

// File: rtl/burst_pix_fifo.sv
module burst_pix_fifo #(
  parameter int unsigned DATA_W = bf_pkg::BF_DATA_W,
  parameter int unsigned ADDR_W = bf_pkg::BF_ADDR_W,
  parameter int unsigned STAGES = bf_pkg::BF_SYNC_STAGES
) (
  input  logic              rst_n,
  input  logic              wr_clk,
  input  logic [DATA_W-1:0] wr_pix,
  input  logic              wr_active,
  input  logic              wr_ctrl,
  output logic              almost_full,
  output logic              overflow,
  input  logic              rd_clk,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_pix,
  output logic              data_valid,
  input  logic [ADDR_W:0]   afull_lvl,
  input  logic [ADDR_W:0]   aempty_lvl
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic              wr_rst_s, rd_rst_s;
  logic              push_req, mem_we, pop;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [ADDR_W:0]   wr_gray, rd_gray, wr_gray_s, rd_gray_s;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_pix_q, rd_pix_d;

  bf_rst_sync u_wr_rst (.clk(wr_clk), .arst_n(rst_n), .srst_n(wr_rst_s));
  bf_rst_sync u_rd_rst (.clk(rd_clk), .arst_n(rst_n), .srst_n(rd_rst_s));

  assign push_req = wr_active | wr_ctrl;

  bf_wr_ctl #(.ADDR_W(ADDR_W)) u_wr_ctl (
    .clk(wr_clk), .rst_n(wr_rst_s), .push_req(push_req),
    .rd_gray_s(rd_gray_s), .afull_lvl(afull_lvl),
    .mem_we(mem_we), .wr_addr(wr_addr), .wr_gray(wr_gray),
    .almost_full(almost_full), .overflow(overflow)
  );

  bf_ptr_sync #(.W(ADDR_W+1), .STAGES(STAGES)) u_w2r (
    .clk(rd_clk), .rst_n(rd_rst_s), .gray_in(wr_gray), .gray_out(wr_gray_s)
  );

  bf_ptr_sync #(.W(ADDR_W+1), .STAGES(STAGES)) u_r2w (
    .clk(wr_clk), .rst_n(wr_rst_s), .gray_in(rd_gray), .gray_out(rd_gray_s)
  );

  bf_rd_ctl #(.ADDR_W(ADDR_W)) u_rd_ctl (
    .clk(rd_clk), .rst_n(rd_rst_s), .rd_en(rd_en),
    .wr_gray_s(wr_gray_s), .afull_lvl(afull_lvl), .aempty_lvl(aempty_lvl),
    .pop(pop), .rd_addr(rd_addr), .rd_gray(rd_gray), .data_valid(data_valid)
  );

  // Storage array: written on the pixel clock, no reset.
  always_ff @(posedge wr_clk) begin
    if (mem_we) mem[wr_addr] <= wr_pix;
  end

  always_comb begin
    rd_pix_d = rd_pix_q;
    if (pop) rd_pix_d = mem[rd_addr];
  end

  always_ff @(posedge rd_clk or negedge rd_rst_s) begin
    if (!rd_rst_s) rd_pix_q <= '0;
    else           rd_pix_q <= rd_pix_d;
  end

  assign rd_pix = rd_pix_q;

  // R1
  qual_gate_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_s)
    !(wr_active || wr_ctrl) |-> !mem_we);

  // R3
  rd_hold_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_s)
    !pop |=> $stable(rd_pix_q));
endmodule

// File: tb/burst_pix_fifo_tb.sv
module burst_pix_fifo_tb;
  localparam int unsigned DW = 20;
  localparam int unsigned AW = 4;
  localparam int DEPTH = 1 << AW;
  localparam int AF = 12;
  localparam int AE = 4;

  logic          rst_n, wr_clk, rd_clk;
  logic [DW-1:0] wr_pix, rd_pix;
  logic          wr_active, wr_ctrl, rd_en;
  logic          almost_full, overflow, data_valid;
  logic [AW:0]   afull_lvl, aempty_lvl;

  int checks = 0, errors = 0;
  logic [DW-1:0] q[$];
  logic [DW-1:0] last_rd;
  bit exp_dv, exp_ovf;

  burst_pix_fifo #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
    .rst_n(rst_n), .wr_clk(wr_clk), .wr_pix(wr_pix), .wr_active(wr_active),
    .wr_ctrl(wr_ctrl), .almost_full(almost_full), .overflow(overflow),
    .rd_clk(rd_clk), .rd_en(rd_en), .rd_pix(rd_pix), .data_valid(data_valid),
    .afull_lvl(afull_lvl), .aempty_lvl(aempty_lvl)
  );

  initial wr_clk = 1'b0;
  always #4 wr_clk = ~wr_clk;
  initial rd_clk = 1'b0;
  always #6.5 rd_clk = ~rd_clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit dv_model(bit prev, int cnt);
    if (cnt >= AF) return 1'b1;
    if (cnt <= AE) return 1'b0;
    return prev;
  endfunction

  task automatic settle();
    repeat (6) @(posedge rd_clk);
    repeat (6) @(posedge wr_clk);
    repeat (6) @(posedge rd_clk);
    exp_dv = dv_model(exp_dv, q.size());
  endtask

  task automatic push(logic [DW-1:0] d, bit act, bit ctl);
    @(negedge wr_clk);
    wr_pix = d; wr_active = act; wr_ctrl = ctl;
    @(posedge wr_clk);
    if (act || ctl) begin
      if (q.size() < DEPTH) q.push_back(d);
      else exp_ovf = 1'b1;
    end
    @(negedge wr_clk);
    wr_active = 1'b0; wr_ctrl = 1'b0;
  endtask

  task automatic pop_one(string req);
    @(negedge rd_clk);
    rd_en = 1'b1;
    @(posedge rd_clk);
    @(negedge rd_clk);
    rd_en = 1'b0;
    if (q.size() > 0) last_rd = q.pop_front();
    chk(req, 32'(rd_pix), 32'(last_rd));
  endtask

  task automatic check_flags(string req);
    chk({req, " almost_full"}, 32'(almost_full), 32'(q.size() >= AF));
    chk({req, " data_valid"}, 32'(data_valid), 32'(exp_dv));
    chk({req, " overflow"}, 32'(overflow), 32'(exp_ovf));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge rd_clk);
    repeat (3) @(posedge wr_clk);
    @(negedge wr_clk);
    rst_n = 1'b1;
    q.delete();
    exp_dv = 1'b0; exp_ovf = 1'b0; last_rd = '0;
    settle();
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F0C_5A17));
    wr_pix = '0; wr_active = 1'b0; wr_ctrl = 1'b0; rd_en = 1'b0;
    afull_lvl = (AW+1)'(AF); aempty_lvl = (AW+1)'(AE);
    rst_n = 1'b0;
    exp_dv = 1'b0; exp_ovf = 1'b0; last_rd = '0;
    repeat (2) @(posedge wr_clk);
    chk("R8 in-reset rd_pix", 32'(rd_pix), 0);
    chk("R8 in-reset data_valid", 32'(data_valid), 0);
    do_reset();
    chk("R8 rd_pix", 32'(rd_pix), 0);
    check_flags("R8");

    // R1: unqualified words are discarded
    push(20'hAAAAA, 1'b0, 1'b0);
    push(20'h12345, 1'b1, 1'b0);
    push(20'hBBBBB, 1'b0, 1'b0);
    push(20'h3C0DE, 1'b0, 1'b1);
    settle();
    pop_one("R1 first");
    pop_one("R1 second");
    // R4: read on empty holds output and pointer
    pop_one("R4 empty hold");
    push(20'h0BEEF, 1'b1, 1'b1);
    settle();
    pop_one("R4 next after empty");
    settle();

    // R5/R6: thresholds and hysteresis
    for (int i = 0; i < AF - 1; i++) push(20'(i + 20'h100), 1'b1, 1'b0);
    settle();
    check_flags("R5 R6 below afull");
    push(20'h77777, 1'b0, 1'b1);
    settle();
    check_flags("R5 R6 at afull");
    while (q.size() > AE + 1) pop_one("R2 drain");
    settle();
    check_flags("R6 hold above aempty");
    pop_one("R2 drain");
    settle();
    check_flags("R6 fall at aempty");
    while (q.size() < AF - 1) push(20'($urandom), 1'b1, 1'b0);
    settle();
    check_flags("R6 stays low below afull");

    // R7/R9: fill to capacity and beyond
    while (q.size() < DEPTH) push(20'($urandom), 1'b1, 1'b0);
    settle();
    chk("R9 no overflow at depth", 32'(overflow), 0);
    push(20'hDEAD1, 1'b1, 1'b0);
    push(20'hDEAD2, 1'b0, 1'b1);
    settle();
    check_flags("R7 R9 overflow");
    while (q.size() > 0) pop_one("R9 R2 full drain");
    settle();
    check_flags("R7 sticky after drain");
    pop_one("R9 dropped word absent");
    do_reset();
    check_flags("R8 R7 reset clears");

    // Random rounds, R2/R3/R5/R6
    for (int r = 0; r < 40; r++) begin
      int nw = int'($urandom_range(0, 14));
      int nr = int'($urandom_range(0, 14));
      for (int k = 0; k < nw; k++) begin
        bit a = 1'($urandom);
        bit c = ($urandom_range(0, 3) == 0);
        push(20'($urandom), a, c);
      end
      settle();
      check_flags("R5 R6 R7 random write");
      for (int k = 0; k < nr; k++) begin
        pop_one("R2 R3 random read");
        repeat ($urandom_range(0, 2)) @(posedge rd_clk);
      end
      settle();
      check_flags("R5 R6 random read");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule